// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for clause-22 management transfers toward an external PHY. Software first sets an MDC divider and an optional preamble in a control register. It then writes one 32-bit command word, and that write starts the transfer. The command word is the serial frame itself, with these fields from the top down:

- a 2-bit start pattern
- a 2-bit opcode
- PHY address
- register address
- turnaround
- 16 data bits

The block shifts the frame out MSB first on a tri-stateable MDIO pin while it generates MDC from the system clock.

For a read, the block releases MDIO at the second turnaround bit and collects the 16 bits the PHY returns. It writes those bits into the low half of the command register. When the last bit has gone out, the block sets a completion flag, and software clears that flag by writing a one to it. A read-only busy flag shows that a transfer is in flight. A command written during a transfer is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A write to register address 1 (command) while idle stores the word and raises `busy` on the next clock edge.
- R2: While busy, MDC toggles once every (divider+1) system clocks, where the divider is control bits 6:0. The first toggle is a rise. MDC is low whenever the block is idle.
- R3: A divider of zero holds MDC low and stalls the transfer with `busy` still set. Writing a nonzero divider lets the transfer resume.
- R4: With control bit 7 set when the command is written, 32 ones are sent before the frame bits.
- R5: Frame bits are sent MSB first (command bit 31 first). MDIO output and output enable change only together with a falling MDC edge.
- R6: When command bits 29:28 are not binary 10, the block drives MDIO for every bit of the transfer.
- R7: When command bits 29:28 equal binary 10 (read), output enable drops from command bit 16 (second turnaround bit) onward. The input is sampled on rising MDC edges for command bits 15:0, MSB first.
- R8: After a read, command register bits 15:0 hold the sampled data and bits 31:16 keep their written value. After a write, the whole command word is unchanged.
- R9: On the falling MDC edge that ends the last bit, `busy` clears and the completion flag sets. The completion flag is status bit 0 at register address 2.
- R10: Writing status bit 0 as one clears the completion flag, and writing zero leaves it alone. If a completion happens in the same cycle as the clear, the flag ends up set.
- R11: A command write while busy is ignored, and the command register keeps its contents.
- R12: After reset, the control register (address 0), the command register and the status register read zero, and MDC and output enable are low. Status bit 1 reads the busy state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 command, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by bus_addr |
| busy | output | 1 | Transfer in flight |
| done_flag | output | 1 | Completion flag (status bit 0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The main function is tried with several transfers:

- A write frame with a small divider and no preamble shows that the bit order is correct and that the pin is driven throughout.
- A read frame with preamble checks the 32-ones lead-in, the release at the turnaround, and the capture of a PHY answer with mixed bits. A command written during this transfer must leave the register untouched.
- A read started with a zero divider shows the stall, and its resumption after the divider is rewritten.
- A write at the typical divider checks the full half-period length.

A behavioural model in the bench predicts MDC, the pin state, busy and the flag on every clock, so a wrong bit, a wrong edge or a wrong release point each shows up as a mismatch.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int REG_AW   = 2;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_CMD  = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT = 2'd2;

  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int DIV_W    = 7;
  localparam int CTRL_W   = DIV_W + 1;
  localparam int PRE_BITS = 32;
  localparam int SEQ_MAX  = PRE_BITS + CMD_W;
  localparam int IDX_W    = $clog2(SEQ_MAX + 1);
  localparam int FIDX_W   = $clog2(CMD_W);
  localparam int REL_POS  = CMD_W - DATA_W - 1;
  localparam int SMP_POS  = CMD_W - DATA_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_OTHER = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  always_comb begin
    tick  = run && (div != '0) && (cnt_q >= div);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (div == '0) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = tick && !mdc_q;
  assign fall_evt = tick &&  mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pre_en,
  input  logic [CMD_W-1:0]  frame,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rd_data
);
  logic              busy_q, busy_d;
  logic              pre_q, pre_d;
  logic [IDX_W-1:0]  k_q, k_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  logic              in_pre, is_rd, released, sample, last, cur_bit;
  logic [IDX_W-1:0]  fk, last_idx;
  logic [FIDX_W-1:0] fpos;

  always_comb begin
    last_idx = pre_q ? IDX_W'(SEQ_MAX - 1) : IDX_W'(CMD_W - 1);
    in_pre   = pre_q && (k_q < IDX_W'(PRE_BITS));
    fk       = k_q - (pre_q ? IDX_W'(PRE_BITS) : '0);
    fpos     = FIDX_W'(CMD_W - 1) - fk[FIDX_W-1:0];
    is_rd    = (mdio_op_e'(frame[CMD_W-3:CMD_W-4]) == OP_READ);
    released = is_rd && !in_pre && (fk >= IDX_W'(REL_POS));
    sample   = rise_evt && is_rd && !in_pre && (fk >= IDX_W'(SMP_POS));
    last     = (k_q == last_idx);
    cur_bit  = in_pre ? 1'b1 : frame[fpos];
  end

  always_comb begin
    busy_d = busy_q;
    pre_d  = pre_q;
    k_d    = k_q;
    rd_d   = rd_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        pre_d  = pre_en;
        k_d    = '0;
        rd_d   = '0;
      end
    end else begin
      if (sample) begin
        rd_d = {rd_q[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (last) begin
          busy_d = 1'b0;
        end else begin
          k_d = k_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      k_q    <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      k_q    <= k_d;
      rd_q   <= rd_d;
    end
  end

  assign busy       = busy_q;
  assign done_pulse = busy_q && fall_evt && last;
  assign mdio_oe    = busy_q && !released;
  assign mdio_o     = busy_q ? cur_bit : 1'b1;
  assign rd_data    = rd_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [CMD_W-1:0]  bus_wdata,
  output logic [CMD_W-1:0]  bus_rdata,
  output logic              busy,
  output logic              done_flag,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [CTRL_W-1:0] ctl_q, ctl_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              done_q, done_d;
  logic              start, done_pulse, rise_evt, fall_evt;
  logic [DATA_W-1:0] rd_data;

  assign start = bus_wr && (bus_addr == A_CMD) && !busy;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (ctl_q[DIV_W-1:0]),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pre_en     (ctl_q[DIV_W]),
    .frame      (cmd_q),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done_pulse (done_pulse),
    .rd_data    (rd_data)
  );

  always_comb begin
    ctl_d  = ctl_q;
    cmd_d  = cmd_q;
    done_d = done_q;
    if (bus_wr && (bus_addr == A_CTRL)) begin
      ctl_d = bus_wdata[CTRL_W-1:0];
    end
    if (start) begin
      cmd_d = bus_wdata;
    end else if (done_pulse && (mdio_op_e'(cmd_q[CMD_W-3:CMD_W-4]) == OP_READ)) begin
      cmd_d[DATA_W-1:0] = rd_data;
    end
    if (done_pulse) begin
      done_d = 1'b1;
    end else if (bus_wr && (bus_addr == A_STAT) && bus_wdata[0]) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      cmd_q  <= cmd_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {{(CMD_W-CTRL_W){1'b0}}, ctl_q};
      A_CMD:   bus_rdata = cmd_q;
      A_STAT:  bus_rdata = {{(CMD_W-2){1'b0}}, busy, done_q};
      default: bus_rdata = '0;
    endcase
  end

  assign done_flag = done_q;
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic              stat_wbit,
  input logic              busy,
  input logic              done_flag,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [15:0]       cmd_hi,
  input logic              done_pulse
);
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CMD && !busy) |=> busy); // R1

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2

  AST_PIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_hi[13:12] != 2'b10) |-> mdio_oe); // R6

  AST_DONE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (done_flag && !busy)); // R9

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && stat_wbit && !done_pulse) |=> !done_flag); // R10

  AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == A_CMD) |=> (cmd_hi == $past(cmd_hi))); // R11
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .stat_wbit  (bus_wdata[0]),
  .busy       (busy),
  .done_flag  (done_flag),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .cmd_hi     (cmd_q[31:16]),
  .done_pulse (done_pulse)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        busy, done_flag, mdc, mdio_o, mdio_oe, mdio_i;

  always #2.5 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .done_flag(done_flag), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // PHY side: counts rising MDC edges with the pin released, answers MSB first
  logic [15:0] phy_val = 16'h0;
  int phy_c = 0;
  always @(posedge mdc) begin
    if (mdio_oe) phy_c = 0;
    else phy_c = phy_c + 1;
  end
  assign mdio_i = (phy_c >= 1 && phy_c <= 16) ? phy_val[16 - phy_c] : 1'b0;

  // Behavioural reference model
  logic        m_busy, m_mdc, m_done, m_pre, m_preq;
  int          m_cnt, m_k, m_n;
  logic [6:0]  m_div;
  logic [31:0] m_cmd;
  logic [15:0] m_data;

  function automatic int m_fk();
    return m_k - (m_preq ? 32 : 0);
  endfunction
  function automatic bit m_inpre();
    return m_preq && (m_k < 32);
  endfunction
  function automatic bit m_isrd();
    return m_cmd[29:28] == 2'b10;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_mdc = 0; m_done = 0; m_pre = 0; m_preq = 0;
      m_cnt = 0; m_k = 0; m_n = 32; m_div = 0; m_cmd = 0; m_data = 0;
    end else begin
      bit ob, set_done;
      ob = m_busy;
      set_done = 0;
      if (m_busy) begin
        if (m_div == 0) m_cnt = 0;
        else if (m_cnt >= m_div) begin
          m_cnt = 0;
          if (!m_mdc) begin
            m_mdc = 1;
            if (m_isrd() && !m_inpre() && m_fk() >= 16) m_data = {m_data[14:0], mdio_i};
          end else begin
            m_mdc = 0;
            if (m_k == m_n - 1) begin
              m_busy = 0;
              set_done = 1;
              if (m_isrd()) m_cmd[15:0] = m_data;
            end else m_k++;
          end
        end else m_cnt++;
      end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin m_div = bus_wdata[6:0]; m_pre = bus_wdata[7]; end
          2'd1: if (!ob) begin
                  m_cmd = bus_wdata; m_busy = 1; m_k = 0; m_cnt = 0; m_mdc = 0;
                  m_preq = m_pre; m_n = m_pre ? 64 : 32; m_data = 0;
                end
          2'd2: if (bus_wdata[0]) m_done = 0;
          default: ;
        endcase
      end
      if (set_done) m_done = 1;
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit eoe;
      eoe = m_busy && !(m_isrd() && !m_inpre() && m_fk() >= 15);
      chk("R2", "mdc", mdc, m_mdc);
      chk("R1", "busy", busy, m_busy);
      chk("R9", "done_flag", done_flag, m_done);
      chk("R7", "mdio_oe", mdio_oe, eoe);
      if (eoe) chk("R5", "mdio_o", mdio_o, m_inpre() ? 1'b1 : m_cmd[31 - m_fk()]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [31:0] W_CMD  = (32'h5 << 28) | (32'd3 << 23) | (32'd4 << 18) | (32'h2 << 16) | 32'hA5C3;
  localparam logic [31:0] R_CMD  = (32'h6 << 28) | (32'd1 << 23) | (32'd2 << 18) | (32'h2 << 16);
  localparam logic [31:0] R_CMD2 = (32'h6 << 28) | (32'd31 << 23) | (32'd17 << 18) | (32'h2 << 16);

  initial begin
    logic [31:0] v;
    int n;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    rd(2'd0, v); chk("R12", "ctrl after reset", v, 32'h0);
    rd(2'd1, v); chk("R12", "cmd after reset", v, 32'h0);
    rd(2'd2, v); chk("R12", "status after reset", v, 32'h0);
    chk("R12", "mdc after reset", mdc, 1'b0);
    chk("R12", "oe after reset", mdio_oe, 1'b0);

    // R6/R5: write frame, divider 1, no preamble
    wr(2'd0, 32'h01);
    wr(2'd1, W_CMD);
    chk("R1", "busy after launch", busy, 1'b1);
    wait_idle();
    rd(2'd2, v); chk("R9", "status after write", v, 32'h1);
    rd(2'd1, v); chk("R8", "cmd kept after write", v, W_CMD);

    // R10: write-one-to-clear
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R10", "zero write keeps flag", v, 32'h1);
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R10", "one write clears flag", v, 32'h0);

    // R4/R7/R11: read with preamble, divider 2, busy write dropped
    phy_val = 16'h4B5A;
    wr(2'd0, 32'h82);
    wr(2'd1, R_CMD);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R12", "busy bit in status", v, 32'h2);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R11", "cmd after busy write", v, R_CMD);
    wait_idle();
    rd(2'd1, v); chk("R8", "read result", v, R_CMD | 32'h4B5A);
    wr(2'd2, 32'h1);

    // R3: divider zero stalls, rewrite resumes
    phy_val = 16'hC3A5;
    wr(2'd0, 32'h00);
    wr(2'd1, R_CMD2);
    repeat (40) @(negedge clk);
    chk("R3", "mdc held low", mdc, 1'b0);
    chk("R3", "still busy", busy, 1'b1);
    wr(2'd0, 32'h03);
    wait_idle();
    rd(2'd1, v); chk("R8", "read result after stall", v, R_CMD2 | 32'hC3A5);
    wr(2'd2, 32'h1);

    // R2: typical divider half period
    wr(2'd0, 32'h9F);
    wr(2'd1, W_CMD);
    n = 0;
    while (!mdc && n < 200) begin @(negedge clk); n++; end
    chk("R2", "clocks to first rise", n, 32);
    wait_idle();
    rd(2'd2, v); chk("R9", "status after long write", v, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule